// File: doc/BRIEF.md
# Trap Entry State Update Unit

This block performs the architectural bookkeeping that happens at the moment a processor takes a trap and delivers it at privileged level. On each clock edge where the take-trap strobe is high, it raises the trap level and the global register level, rewrites the processor state word into its trap-handler form, and moves the register window pointer as the trap type demands. In the same edge it stores the interrupted context into a small bank that holds one entry per trap level. The entry is written at the new trap level and holds a packed state word, the two program counters, the hyperprivileged state and the trap type.

The surrounding pipeline supplies the current control register values every cycle and raises the strobe for one cycle per trap. It reads the updated level, global level, state word and window pointer from the registered outputs. A combinational read port returns the saved entry of any trap level, so a handler or a trap-return path can fetch it. When the strobe is low, every register and every saved entry holds.

The trap type picks one of four window-move modes, an enumerated value decoded with a unique case. KEEP leaves the pointer alone. CLEAN steps it forward by one. SPILL advances it by the free-window count plus two. FILL steps it back by one. The three moving modes wrap modulo the number of windows.

Top module: `trap_entry_unit`

## Requirements
- R1: After a trap, `new_tl` equals `cur_tl + 1`, saturating at MAX_TL (default 6).
- R2: After a trap, `new_gl` equals `cur_gl + 1`, saturating at MAX_GL (default 3).
- R3: The saved state word at level `new_tl` carries GL in bits 42:40, CCR in 39:32, ASI in 31:24, the old PSTATE in 20:8 and the old CWP in 4:0. All other bits are zero.
- R4: The entry at level `new_tl` also stores the PC, the NPC, the HPSTATE and the 9-bit trap type.
- R5: `new_pstate` is the old PSTATE with bit 4 (FPU enable) and bit 2 (privileged) set, and bit 3 (address mask) and bit 1 (interrupt enable) cleared. Bit 9 (current little-endian) takes the value of bit 8 (trap little-endian). All other bits are unchanged.
- R6: Trap type 0x024 (CLEAN) gives `new_cwp = (cur_cwp + 1) mod NWIN`, with NWIN defaulting to 8.
- R7: Trap types 0x080 to 0x0BF (SPILL) give `new_cwp = (cur_cwp + cur_cansave + 2) mod NWIN`.
- R8: Trap types 0x0C0 to 0x0FF (FILL) give `new_cwp = (cur_cwp - 1) mod NWIN`, so 0 wraps to NWIN-1.
- R9: Any other trap type (KEEP) leaves `new_cwp` equal to `cur_cwp`.
- R10: With `take_trap` low, every output and every saved entry holds, whatever the other inputs do.
- R11: While reset is asserted, all registered outputs and all saved entries are zero.
- R12: A trap writes only the entry at its new level. The entries of other levels keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_trap | input | 1 | Take-trap strobe, one cycle per trap |
| trap_type | input | 9 | Type of the trap being taken |
| cur_tl | input | LVL_W (3) | Current trap level |
| cur_gl | input | 3 | Current global register level |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address space identifier |
| cur_pstate | input | 13 | Current processor state word |
| cur_hpstate | input | HPS_W (12) | Current hyperprivileged state |
| cur_cwp | input | 5 | Current window pointer |
| cur_cansave | input | 5 | Current count of free windows |
| cur_pc | input | ADDR_W (64) | Program counter of the trapping instruction |
| cur_npc | input | ADDR_W (64) | Next program counter |
| new_tl | output | LVL_W (3) | Trap level after the trap |
| new_gl | output | 3 | Global level after the trap |
| new_pstate | output | 13 | State word after the trap |
| new_cwp | output | 5 | Window pointer after the trap |
| rd_lvl | input | LVL_W (3) | Trap level whose saved entry is read |
| rd_tstate | output | 64 | Saved packed state word |
| rd_tpc | output | ADDR_W (64) | Saved program counter |
| rd_tnpc | output | ADDR_W (64) | Saved next program counter |
| rd_htstate | output | HPS_W (12) | Saved hyperprivileged state |
| rd_tt | output | 9 | Saved trap type |

## Verification
The bench probes the edges of every window-move range: 0x07F and 0x100 sit just outside the SPILL and FILL decodes, 0x025 is next to CLEAN, and 0x0BF and 0x0C0 are the last SPILL type and the first FILL type. A decoder with an off-by-one boundary would move a pointer that should stay put. It also drives wrap cases: CLEAN from window 7, FILL from window 0, and SPILL sums of 9, 12 and 16. Arithmetic missing the modulo would leave values of 8 or more in the pointer, or a wrong window after a borrow. Trap level and global level are driven at their maximums to catch counters that roll over to zero. Little-endian states in both directions catch a design that ORs bit 9 instead of copying it. Changing every input with the strobe low, and trapping at two separate levels, exposes writes that ignore the strobe or touch the wrong entry.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    // Architectural field widths fixed by the saved state layout
    localparam int GL_W    = 3;
    localparam int CCR_W   = 8;
    localparam int ASI_W   = 8;
    localparam int PS_W    = 13;
    localparam int CWP_W   = 5;
    localparam int TT_W    = 9;
    localparam int WORD_W  = 64;

    // Field placement inside the saved state word
    localparam int TS_GL_LSB  = 40;
    localparam int TS_CCR_LSB = 32;
    localparam int TS_ASI_LSB = 24;
    localparam int TS_PS_LSB  = 8;
    localparam int TS_CWP_LSB = 0;

    // Processor state word bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    localparam logic [TT_W-1:0] TT_CLEAN = 9'h024;

    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_CLEAN = 2'd1,
        WIN_SPILL = 2'd2,
        WIN_FILL  = 2'd3
    } win_move_e;

    // 0x080..0x0BF has bits 8:6 = 010, 0x0C0..0x0FF has bits 8:6 = 011
    function automatic win_move_e classify_tt(input logic [TT_W-1:0] tt);
        if (tt == TT_CLEAN)
            return WIN_CLEAN;
        else if (tt[8:6] == 3'b010)
            return WIN_SPILL;
        else if (tt[8:6] == 3'b011)
            return WIN_FILL;
        else
            return WIN_KEEP;
    endfunction

endpackage

// File: rtl/trap_win_adjust.sv
module trap_win_adjust
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [CWP_W-1:0] cwp_cur,
    input  logic [CWP_W-1:0] cansave,
    input  logic [TT_W-1:0]  tt,
    output logic [CWP_W-1:0] cwp_nxt
);

    localparam int  SUM_W = CWP_W + 2;
    localparam bit  POW2  = ((NWIN & (NWIN - 1)) == 0);

    win_move_e          move;
    logic [SUM_W-1:0]   raw_sum;
    logic [SUM_W-1:0]   wrapped;

    always_comb begin
        move    = classify_tt(tt);
        raw_sum = SUM_W'(cwp_cur);
        unique case (move)
            WIN_KEEP:  raw_sum = SUM_W'(cwp_cur);
            WIN_CLEAN: raw_sum = SUM_W'(cwp_cur) + SUM_W'(1);
            WIN_SPILL: raw_sum = SUM_W'(cwp_cur) + SUM_W'(cansave) + SUM_W'(2);
            WIN_FILL:  raw_sum = SUM_W'(cwp_cur) + SUM_W'(NWIN - 1);
        endcase
    end

    generate
        if (POW2) begin : g_mask
            always_comb wrapped = raw_sum & SUM_W'(NWIN - 1);
        end else begin : g_mod
            always_comb wrapped = raw_sum % SUM_W'(NWIN);
        end
    endgenerate

    always_comb begin
        if (move == WIN_KEEP)
            cwp_nxt = cwp_cur;
        else
            cwp_nxt = CWP_W'(wrapped);
    end

endmodule

// File: rtl/trap_ctl_xform.sv
module trap_ctl_xform
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int MAX_GL = 3,
    parameter int LVL_W  = 3
) (
    input  logic [LVL_W-1:0]  tl_cur,
    input  logic [GL_W-1:0]   gl_cur,
    input  logic [CCR_W-1:0]  ccr_cur,
    input  logic [ASI_W-1:0]  asi_cur,
    input  logic [PS_W-1:0]   ps_cur,
    input  logic [CWP_W-1:0]  cwp_cur,
    output logic [LVL_W-1:0]  tl_nxt,
    output logic [GL_W-1:0]   gl_nxt,
    output logic [PS_W-1:0]   ps_nxt,
    output logic [WORD_W-1:0] tstate_word
);

    always_comb begin
        if (tl_cur >= LVL_W'(MAX_TL))
            tl_nxt = LVL_W'(MAX_TL);
        else
            tl_nxt = tl_cur + LVL_W'(1);

        if (gl_cur >= GL_W'(MAX_GL))
            gl_nxt = GL_W'(MAX_GL);
        else
            gl_nxt = gl_cur + GL_W'(1);
    end

    always_comb begin
        ps_nxt          = ps_cur;
        ps_nxt[PS_PEF]  = 1'b1;
        ps_nxt[PS_PRIV] = 1'b1;
        ps_nxt[PS_AM]   = 1'b0;
        ps_nxt[PS_IE]   = 1'b0;
        ps_nxt[PS_CLE]  = ps_cur[PS_TLE];
    end

    always_comb begin
        tstate_word = '0;
        tstate_word[TS_GL_LSB  +: GL_W]  = gl_cur;
        tstate_word[TS_CCR_LSB +: CCR_W] = ccr_cur;
        tstate_word[TS_ASI_LSB +: ASI_W] = asi_cur;
        tstate_word[TS_PS_LSB  +: PS_W]  = ps_cur;
        tstate_word[TS_CWP_LSB +: CWP_W] = cwp_cur;
    end

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank
    import trap_entry_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 64,
    parameter int HPS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [WORD_W-1:0] wr_tstate,
    input  logic [ADDR_W-1:0] wr_tpc,
    input  logic [ADDR_W-1:0] wr_tnpc,
    input  logic [HPS_W-1:0]  wr_htstate,
    input  logic [TT_W-1:0]   wr_tt,
    input  logic [LVL_W-1:0]  rd_lvl,
    output logic [WORD_W-1:0] rd_tstate,
    output logic [ADDR_W-1:0] rd_tpc,
    output logic [ADDR_W-1:0] rd_tnpc,
    output logic [HPS_W-1:0]  rd_htstate,
    output logic [TT_W-1:0]   rd_tt
);

    localparam int DEPTH = MAX_TL + 1;

    logic [WORD_W-1:0] tstate_mem  [DEPTH];
    logic [ADDR_W-1:0] tpc_mem     [DEPTH];
    logic [ADDR_W-1:0] tnpc_mem    [DEPTH];
    logic [HPS_W-1:0]  htstate_mem [DEPTH];
    logic [TT_W-1:0]   tt_mem      [DEPTH];
    logic              rd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tstate_mem[i]  <= '0;
                tpc_mem[i]     <= '0;
                tnpc_mem[i]    <= '0;
                htstate_mem[i] <= '0;
                tt_mem[i]      <= '0;
            end
        end else if (wr_en) begin
            tstate_mem[wr_lvl]  <= wr_tstate;
            tpc_mem[wr_lvl]     <= wr_tpc;
            tnpc_mem[wr_lvl]    <= wr_tnpc;
            htstate_mem[wr_lvl] <= wr_htstate;
            tt_mem[wr_lvl]      <= wr_tt;
        end
    end

    always_comb begin
        rd_ok      = (32'(rd_lvl) <= MAX_TL);
        rd_tstate  = rd_ok ? tstate_mem[rd_lvl]  : '0;
        rd_tpc     = rd_ok ? tpc_mem[rd_lvl]     : '0;
        rd_tnpc    = rd_ok ? tnpc_mem[rd_lvl]    : '0;
        rd_htstate = rd_ok ? htstate_mem[rd_lvl] : '0;
        rd_tt      = rd_ok ? tt_mem[rd_lvl]      : '0;
    end

    // R4
    tt_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tt_mem[$past(wr_lvl)] == $past(wr_tt));

    // R4
    pc_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tpc_mem[$past(wr_lvl)] == $past(wr_tpc));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int MAX_TL = 6,
    parameter int MAX_GL = 3,
    parameter int ADDR_W = 64,
    parameter int HPS_W  = 12,
    localparam int LVL_W = $clog2(MAX_TL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_trap,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [LVL_W-1:0]  cur_tl,
    input  logic [GL_W-1:0]   cur_gl,
    input  logic [CCR_W-1:0]  cur_ccr,
    input  logic [ASI_W-1:0]  cur_asi,
    input  logic [PS_W-1:0]   cur_pstate,
    input  logic [HPS_W-1:0]  cur_hpstate,
    input  logic [CWP_W-1:0]  cur_cwp,
    input  logic [CWP_W-1:0]  cur_cansave,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_npc,
    output logic [LVL_W-1:0]  new_tl,
    output logic [GL_W-1:0]   new_gl,
    output logic [PS_W-1:0]   new_pstate,
    output logic [CWP_W-1:0]  new_cwp,
    input  logic [LVL_W-1:0]  rd_lvl,
    output logic [WORD_W-1:0] rd_tstate,
    output logic [ADDR_W-1:0] rd_tpc,
    output logic [ADDR_W-1:0] rd_tnpc,
    output logic [HPS_W-1:0]  rd_htstate,
    output logic [TT_W-1:0]   rd_tt
);

    logic [LVL_W-1:0]  tl_nxt;
    logic [GL_W-1:0]   gl_nxt;
    logic [PS_W-1:0]   ps_nxt;
    logic [CWP_W-1:0]  cwp_nxt;
    logic [WORD_W-1:0] tstate_word;

    trap_ctl_xform #(
        .MAX_TL (MAX_TL),
        .MAX_GL (MAX_GL),
        .LVL_W  (LVL_W)
    ) u_ctl (
        .tl_cur      (cur_tl),
        .gl_cur      (cur_gl),
        .ccr_cur     (cur_ccr),
        .asi_cur     (cur_asi),
        .ps_cur      (cur_pstate),
        .cwp_cur     (cur_cwp),
        .tl_nxt      (tl_nxt),
        .gl_nxt      (gl_nxt),
        .ps_nxt      (ps_nxt),
        .tstate_word (tstate_word)
    );

    trap_win_adjust #(
        .NWIN (NWIN)
    ) u_win (
        .cwp_cur (cur_cwp),
        .cansave (cur_cansave),
        .tt      (trap_type),
        .cwp_nxt (cwp_nxt)
    );

    trap_save_bank #(
        .MAX_TL (MAX_TL),
        .LVL_W  (LVL_W),
        .ADDR_W (ADDR_W),
        .HPS_W  (HPS_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (take_trap),
        .wr_lvl     (tl_nxt),
        .wr_tstate  (tstate_word),
        .wr_tpc     (cur_pc),
        .wr_tnpc    (cur_npc),
        .wr_htstate (cur_hpstate),
        .wr_tt      (trap_type),
        .rd_lvl     (rd_lvl),
        .rd_tstate  (rd_tstate),
        .rd_tpc     (rd_tpc),
        .rd_tnpc    (rd_tnpc),
        .rd_htstate (rd_htstate),
        .rd_tt      (rd_tt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_tl     <= '0;
            new_gl     <= '0;
            new_pstate <= '0;
            new_cwp    <= '0;
        end else if (take_trap) begin
            new_tl     <= tl_nxt;
            new_gl     <= gl_nxt;
            new_pstate <= ps_nxt;
            new_cwp    <= cwp_nxt;
        end
    end

    // R1
    tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && (32'(cur_tl) < MAX_TL)) |=> (32'(new_tl) == 32'($past(cur_tl)) + 1));

    // R2
    gl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (32'(new_gl) <= MAX_GL));

    // R5
    ps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (new_pstate[PS_PEF] && new_pstate[PS_PRIV]
                       && !new_pstate[PS_AM] && !new_pstate[PS_IE]));

    // R6
    clean_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && trap_type == TT_CLEAN)
            |=> (32'(new_cwp) == (32'($past(cur_cwp)) + 1) % NWIN));

    // R9
    keep_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && classify_tt(trap_type) == WIN_KEEP) |=> (new_cwp == $past(cur_cwp)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |=> ($stable(new_tl) && $stable(new_gl)
                        && $stable(new_pstate) && $stable(new_cwp)));

endmodule

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;

    typedef struct packed {
        logic [2:0]  tl;
        logic [2:0]  gl;
        logic [12:0] ps;
        logic [4:0]  cwp;
        logic [4:0]  cs;
        logic [8:0]  tt;
        logic [2:0]  e_tl;
        logic [2:0]  e_gl;
        logic [12:0] e_ps;
        logic [4:0]  e_cwp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd0, 13'h0000, 5'd3, 5'd0, 9'h024, 3'd1, 3'd1, 13'h0014, 5'd4},
        '{3'd1, 3'd1, 13'h000A, 5'd7, 5'd0, 9'h024, 3'd2, 3'd2, 13'h0014, 5'd0},
        '{3'd2, 3'd2, 13'h0100, 5'd2, 5'd1, 9'h080, 3'd3, 3'd3, 13'h0314, 5'd5},
        '{3'd3, 3'd3, 13'h0200, 5'd6, 5'd4, 9'h0BF, 3'd4, 3'd3, 13'h0014, 5'd4},
        '{3'd4, 3'd0, 13'h1FFF, 5'd0, 5'd0, 9'h0C0, 3'd5, 3'd1, 13'h1FF5, 5'd7},
        '{3'd5, 3'd1, 13'h00E0, 5'd5, 5'd2, 9'h0FF, 3'd6, 3'd2, 13'h00F4, 5'd4},
        '{3'd6, 3'd2, 13'h0000, 5'd3, 5'd6, 9'h07F, 3'd6, 3'd3, 13'h0014, 5'd3},
        '{3'd0, 3'd0, 13'h0008, 5'd1, 5'd3, 9'h100, 3'd1, 3'd1, 13'h0014, 5'd1},
        '{3'd2, 3'd1, 13'h0000, 5'd2, 5'd0, 9'h025, 3'd3, 3'd2, 13'h0014, 5'd2},
        '{3'd1, 3'd0, 13'h0002, 5'd0, 5'd7, 9'h0A3, 3'd2, 3'd1, 13'h0014, 5'd1},
        '{3'd3, 3'd2, 13'h0000, 5'd7, 5'd7, 9'h0BF, 3'd4, 3'd3, 13'h0014, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_trap = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [2:0]  cur_tl = '0;
    logic [2:0]  cur_gl = '0;
    logic [7:0]  cur_ccr = '0;
    logic [7:0]  cur_asi = '0;
    logic [12:0] cur_pstate = '0;
    logic [11:0] cur_hpstate = '0;
    logic [4:0]  cur_cwp = '0;
    logic [4:0]  cur_cansave = '0;
    logic [63:0] cur_pc = '0;
    logic [63:0] cur_npc = '0;
    logic [2:0]  rd_lvl = '0;
    logic [2:0]  new_tl;
    logic [2:0]  new_gl;
    logic [12:0] new_pstate;
    logic [4:0]  new_cwp;
    logic [63:0] rd_tstate;
    logic [63:0] rd_tpc;
    logic [63:0] rd_tnpc;
    logic [11:0] rd_htstate;
    logic [8:0]  rd_tt;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trap_entry_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_trap   (take_trap),
        .trap_type   (trap_type),
        .cur_tl      (cur_tl),
        .cur_gl      (cur_gl),
        .cur_ccr     (cur_ccr),
        .cur_asi     (cur_asi),
        .cur_pstate  (cur_pstate),
        .cur_hpstate (cur_hpstate),
        .cur_cwp     (cur_cwp),
        .cur_cansave (cur_cansave),
        .cur_pc      (cur_pc),
        .cur_npc     (cur_npc),
        .new_tl      (new_tl),
        .new_gl      (new_gl),
        .new_pstate  (new_pstate),
        .new_cwp     (new_cwp),
        .rd_lvl      (rd_lvl),
        .rd_tstate   (rd_tstate),
        .rd_tpc      (rd_tpc),
        .rd_tnpc     (rd_tnpc),
        .rd_htstate  (rd_htstate),
        .rd_tt       (rd_tt)
    );

    function automatic logic [63:0] pack_word(input logic [2:0] gl, input logic [7:0] ccr,
                                              input logic [7:0] asi, input logic [12:0] ps,
                                              input logic [4:0] cwp);
        return {21'b0, gl, ccr, asi, 3'b0, ps, 3'b0, cwp};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] tl, input logic [2:0] gl, input logic [12:0] ps,
                         input logic [4:0] cwp, input logic [4:0] cs, input logic [8:0] tt,
                         input logic [7:0] ccr, input logic [7:0] asi, input logic [63:0] pc,
                         input logic [11:0] hps, input logic strobe);
        @(negedge clk);
        cur_tl = tl; cur_gl = gl; cur_pstate = ps; cur_cwp = cwp; cur_cansave = cs;
        trap_type = tt; cur_ccr = ccr; cur_asi = asi; cur_pc = pc; cur_npc = pc + 64'd4;
        cur_hpstate = hps; take_trap = strobe;
        @(negedge clk);
        take_trap = 1'b0;
    endtask

    task automatic read_lvl(input logic [2:0] lvl);
        rd_lvl = lvl;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] keep_word;
        logic [63:0] keep_pc;
        logic [4:0]  hold_cwp;
        logic [12:0] hold_ps;

        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "tl at reset", 64'(new_tl), 64'd0);
        check("R11", "pstate at reset", 64'(new_pstate), 64'd0);
        read_lvl(3'd1);
        check("R11", "saved word at reset", rd_tstate, 64'd0);
        rst_n = 1'b1;

        // Vector table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  ccr;
            logic [7:0]  asi;
            logic [63:0] pc;
            logic [11:0] hps;
            ccr = 8'h30 + 8'(i);
            asi = 8'hA0 + 8'(i);
            pc  = 64'h0000_4000_0000_0000 + 64'(i) * 64'h40;
            hps = 12'h5A0 + 12'(i);
            drive(VECS[i].tl, VECS[i].gl, VECS[i].ps, VECS[i].cwp, VECS[i].cs, VECS[i].tt,
                  ccr, asi, pc, hps, 1'b1);
            check("R1", $sformatf("vec %0d tl", i), 64'(new_tl), 64'(VECS[i].e_tl));
            check("R2", $sformatf("vec %0d gl", i), 64'(new_gl), 64'(VECS[i].e_gl));
            check("R5", $sformatf("vec %0d pstate", i), 64'(new_pstate), 64'(VECS[i].e_ps));
            check("R6 R7 R8 R9", $sformatf("vec %0d cwp tt=%0h", i, VECS[i].tt),
                  64'(new_cwp), 64'(VECS[i].e_cwp));
            read_lvl(VECS[i].e_tl);
            check("R3", $sformatf("vec %0d saved word", i), rd_tstate,
                  pack_word(VECS[i].gl, ccr, asi, VECS[i].ps, VECS[i].cwp));
            check("R4", $sformatf("vec %0d tpc", i), rd_tpc, pc);
            check("R4", $sformatf("vec %0d tnpc", i), rd_tnpc, pc + 64'd4);
            check("R4", $sformatf("vec %0d htstate", i), 64'(rd_htstate), 64'(hps));
            check("R4", $sformatf("vec %0d tt", i), 64'(rd_tt), 64'(VECS[i].tt));
        end

        // R12: trap into level 2, then level 5, level 2 untouched
        drive(3'd1, 3'd0, 13'h0000, 5'd4, 5'd1, 9'h011, 8'h11, 8'h22,
              64'hDEAD_0000, 12'h0AB, 1'b1);
        read_lvl(3'd2);
        keep_word = rd_tstate;
        keep_pc   = rd_tpc;
        drive(3'd4, 3'd1, 13'h0100, 5'd6, 5'd2, 9'h030, 8'h77, 8'h88,
              64'hBEEF_0000, 12'h0CD, 1'b1);
        read_lvl(3'd2);
        check("R12", "level 2 word after level 5 trap", rd_tstate, keep_word);
        check("R12", "level 2 pc after level 5 trap", rd_tpc, keep_pc);
        read_lvl(3'd5);
        check("R12", "level 5 pc written", rd_tpc, 64'hBEEF_0000);

        // R10: strobe low, every input changes, nothing moves
        hold_cwp = new_cwp;
        hold_ps  = new_pstate;
        drive(3'd0, 3'd0, 13'h1234, 5'd1, 5'd5, 9'h024, 8'hFF, 8'hFF,
              64'h1111_2222, 12'hFFF, 1'b0);
        @(negedge clk);
        check("R10", "tl with strobe low", 64'(new_tl), 64'd5);
        check("R10", "cwp with strobe low", 64'(new_cwp), 64'(hold_cwp));
        check("R10", "pstate with strobe low", 64'(new_pstate), 64'(hold_ps));
        read_lvl(3'd1);
        check("R10", "level 1 pc with strobe low", rd_tpc, 64'h1111_2222 - 64'h1111_2222 + 64'h0000_4000_0000_01C0);
        read_lvl(3'd5);
        check("R10", "level 5 tt with strobe low", 64'(rd_tt), 64'h030);

        // R11: reset mid-run clears outputs and entries
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11", "cwp after reset", 64'(new_cwp), 64'd0);
        check("R11", "gl after reset", 64'(new_gl), 64'd0);
        read_lvl(3'd5);
        check("R11", "level 5 pc after reset", rd_tpc, 64'd0);
        check("R11", "level 5 tt after reset", 64'(rd_tt), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule